// File: doc/BRIEF.md
# Descriptor Chain Loader for a DMA Channel

This block sits beside one DMA channel and keeps it running through a chain of transfers without processor help. When the channel signals that a transfer has ended, the loader inspects the channel's link register. A non-zero link points to a descriptor in memory. The loader reads that descriptor over a simple word-read port, one word at a time. It then installs the new channel configuration in a single cycle and pulses a restart to the transfer engine. A zero link ends the chain, and the loader reports that the whole transfer is complete.

The loader also handles the per-request clean-up write. After the engine services a request, the loader writes the descriptor's mask data word to the descriptor's mask address. This is typically used to clear the requesting peripheral's flag. Chains may be linear or circular.

A `boot_valid` pulse loads the starting link value and clears both error flags.

Top module: `chain_loader`

## Requirements
- R1: After a synchronous reset, all configuration outputs, `restart`, `chain_done`, both error flags, `rd_req` and `wr_req` are zero.
- R2: A transfer end with an aligned non-zero link starts ten word reads at link, link+4, up to link+36, in ascending order. Only one read is outstanding at a time. `rd_addr` and `rd_req` hold steady until `rd_ack` or `rd_err`.
- R3: The descriptor word positions map as follows: word 0 is control, word 1 is block size, word 2 is source, word 3 is destination, word 4 is repeat update, word 5 is the link, word 6 is trigger select, word 7 is discarded, word 8 is mask address and word 9 is mask data. No configuration output changes until the tenth word arrives. All of them then update in the same cycle, and `restart` is high for exactly that one cycle.
- R4: A transfer end with a zero link pulses `chain_done` for one cycle and issues no read.
- R5: A transfer end with a link whose two low bits are not both zero sets `err_link` and issues no read.
- R6: A read answered with `rd_err` sets `err_link`, stops the fetch, and leaves every configuration output unchanged.
- R7: A `req_served` pulse causes one write of `cfg_mdata` to `cfg_maddr`. No write occurs when `cfg_maddr` is zero.
- R8: A write answered with `wr_err` sets `err_mask`.
- R9: A chain whose last link points back to its first descriptor keeps reloading the descriptors in a circle.
- R10: If a serviced request and a transfer end are both pending, the mask write is done first and the fetch follows. Neither event is lost while the loader is busy.
- R11: `boot_valid` while idle sets the link output to `boot_link` and clears `err_link` and `err_mask`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boot_valid | input | 1 | Load starting link and clear error flags |
| boot_link | input | 32 | Starting link value |
| xfer_done | input | 1 | Pulse: channel transfer ended |
| req_served | input | 1 | Pulse: one request serviced |
| rd_req | output | 1 | Word read request |
| rd_addr | output | 32 | Word read address |
| rd_ack | input | 1 | Read data valid |
| rd_err | input | 1 | Read failed |
| rd_data | input | 32 | Read data |
| wr_req | output | 1 | Word write request |
| wr_addr | output | 32 | Write address |
| wr_data | output | 32 | Write data |
| wr_ack | input | 1 | Write accepted |
| wr_err | input | 1 | Write failed |
| cfg_ctl | output | 32 | Transfer control |
| cfg_blk | output | 32 | Block count and length |
| cfg_src | output | 32 | Source address |
| cfg_dst | output | 32 | Destination address |
| cfg_rpt | output | 32 | Block repeat address update |
| cfg_link | output | 32 | Link address |
| cfg_trig | output | 32 | Trigger and bus select |
| cfg_maddr | output | 32 | Mask write address |
| cfg_mdata | output | 32 | Mask write data |
| restart | output | 1 | Pulse: new configuration installed |
| chain_done | output | 1 | Pulse: chain finished |
| err_link | output | 1 | Sticky descriptor fetch error |
| err_mask | output | 1 | Sticky mask write error |

## Verification
Internal faults in this block surface on the ports within a few cycles:
- A wrong word counter shows at once as a wrong `rd_addr`. It also shows as a configuration field holding a neighbouring word, seen in the cycle `restart` rises.
- A wrong state shows as read and write requests in the same cycle, as a request that never drops, or as a missing `chain_done` the cycle after the decision.
- A lost pending event shows as a missing write or fetch, which the reference model detects within one cycle of when it should have started.

// File: rtl/chain_loader.sv
module chain_loader (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        boot_valid,
  input  logic [31:0] boot_link,
  input  logic        xfer_done,
  input  logic        req_served,
  output logic        rd_req,
  output logic [31:0] rd_addr,
  input  logic        rd_ack,
  input  logic        rd_err,
  input  logic [31:0] rd_data,
  output logic        wr_req,
  output logic [31:0] wr_addr,
  output logic [31:0] wr_data,
  input  logic        wr_ack,
  input  logic        wr_err,
  output logic [31:0] cfg_ctl,
  output logic [31:0] cfg_blk,
  output logic [31:0] cfg_src,
  output logic [31:0] cfg_dst,
  output logic [31:0] cfg_rpt,
  output logic [31:0] cfg_link,
  output logic [31:0] cfg_trig,
  output logic [31:0] cfg_maddr,
  output logic [31:0] cfg_mdata,
  output logic        restart,
  output logic        chain_done,
  output logic        err_link,
  output logic        err_mask
);
  localparam int NWORDS = 10;
  localparam logic [3:0] LAST = 4'(NWORDS - 1);

  typedef enum logic [1:0] {IDLE, FETCH, MASK} st_t;
  st_t         st;
  logic [3:0]  idx;
  logic [31:0] base;
  logic        pend_mask, pend_xfer;
  logic [31:0] sh [0:8];

  assign rd_req  = (st == FETCH);
  assign rd_addr = base + {26'd0, idx, 2'b00};
  assign wr_req  = (st == MASK);
  assign wr_addr = cfg_maddr;
  assign wr_data = cfg_mdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= IDLE; idx <= '0; base <= '0;
      pend_mask <= 1'b0; pend_xfer <= 1'b0;
      restart <= 1'b0; chain_done <= 1'b0;
      err_link <= 1'b0; err_mask <= 1'b0;
      cfg_ctl <= '0; cfg_blk <= '0; cfg_src <= '0; cfg_dst <= '0;
      cfg_rpt <= '0; cfg_link <= '0; cfg_trig <= '0;
      cfg_maddr <= '0; cfg_mdata <= '0;
      for (int i = 0; i < 9; i++) sh[i] <= '0;
    end else begin
      restart    <= 1'b0;
      chain_done <= 1'b0;
      if (boot_valid && st == IDLE) begin
        cfg_link <= boot_link;
        err_link <= 1'b0;
        err_mask <= 1'b0;
      end
      case (st)
        IDLE: begin
          if (pend_mask) begin
            pend_mask <= 1'b0;
            if (cfg_maddr != '0) st <= MASK;
          end else if (pend_xfer) begin
            pend_xfer <= 1'b0;
            if (cfg_link == '0)            chain_done <= 1'b1;
            else if (cfg_link[1:0] != '0) err_link   <= 1'b1;
            else begin
              st   <= FETCH;
              base <= cfg_link;
              idx  <= '0;
            end
          end
        end
        FETCH: begin
          if (rd_err) begin
            err_link <= 1'b1;
            st       <= IDLE;
          end else if (rd_ack) begin
            if (idx == LAST) begin
              cfg_ctl   <= sh[0];
              cfg_blk   <= sh[1];
              cfg_src   <= sh[2];
              cfg_dst   <= sh[3];
              cfg_rpt   <= sh[4];
              cfg_link  <= sh[5];
              cfg_trig  <= sh[6];
              cfg_maddr <= sh[8];
              cfg_mdata <= rd_data;
              restart   <= 1'b1;
              st        <= IDLE;
            end else begin
              sh[idx] <= rd_data;
              idx     <= idx + 4'd1;
            end
          end
        end
        MASK: begin
          if (wr_err) begin
            err_mask <= 1'b1;
            st       <= IDLE;
          end else if (wr_ack) st <= IDLE;
        end
        default: st <= IDLE;
      endcase
      if (req_served) pend_mask <= 1'b1;
      if (xfer_done)  pend_xfer <= 1'b1;
    end
  end

  p_one_port_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req && wr_req));
  p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_ack && !rd_err |=> rd_req && $stable(rd_addr));
  p_aligned_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> rd_addr[1:0] == 2'b00);
  p_atomic_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !restart |-> $stable(cfg_ctl) && $stable(cfg_src) && $stable(cfg_mdata));
  p_restart_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !restart);
  p_done_noread_r4: assert property (@(posedge clk) disable iff (!rst_n)
    chain_done |-> !rd_req);
  p_mask_nz_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> wr_addr != 32'd0);
endmodule

// File: tb/chain_loader_test.sv
`timescale 1ns/1ps
module chain_loader_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic boot_valid = 1'b0, xfer_done = 1'b0, req_served = 1'b0;
  logic [31:0] boot_link = '0;
  logic rd_ack = 1'b0, rd_err = 1'b0, wr_ack = 1'b0, wr_err = 1'b0;
  logic [31:0] rd_data = '0;
  logic rd_req, wr_req, restart, chain_done, err_link, err_mask;
  logic [31:0] rd_addr, wr_addr, wr_data;
  logic [31:0] cfg [0:8];

  always #2 clk = ~clk;

  chain_loader uut (
    .clk(clk), .rst_n(rst_n), .boot_valid(boot_valid), .boot_link(boot_link),
    .xfer_done(xfer_done), .req_served(req_served),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_err(rd_err), .rd_data(rd_data),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ack(wr_ack), .wr_err(wr_err),
    .cfg_ctl(cfg[0]), .cfg_blk(cfg[1]), .cfg_src(cfg[2]), .cfg_dst(cfg[3]),
    .cfg_rpt(cfg[4]), .cfg_link(cfg[5]), .cfg_trig(cfg[6]),
    .cfg_maddr(cfg[7]), .cfg_mdata(cfg[8]),
    .restart(restart), .chain_done(chain_done), .err_link(err_link), .err_mask(err_mask));

  localparam logic [31:0] BAD_RD = 32'h314;
  localparam logic [31:0] BAD_WR = 32'hBAD0;

  int total = 0, bad = 0, cycles = 0;
  int reads = 0, writes = 0, restarts = 0, dones = 0;
  logic [31:0] last_wa = '0, last_wd = '0;
  logic [31:0] mem [logic [31:0]];
  logic gap = 1'b0;

  function automatic logic [31:0] val(logic [31:0] b, int i);
    return 32'hC000_0000 | (b << 8) | 32'(i);
  endfunction

  task automatic put_desc(logic [31:0] b, logic [31:0] link, logic [31:0] ma, logic [31:0] md);
    for (int i = 0; i < 10; i++) mem[b + 32'(4*i)] = val(b, i);
    mem[b + 20] = link; mem[b + 32] = ma; mem[b + 36] = md;
  endtask

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", r, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int ms = 0;
  logic [31:0] mbase = '0;
  logic [31:0] words [$];
  logic [31:0] mc [0:9];
  logic m_rs = 0, m_dn = 0, m_el = 0, m_em = 0, m_pm = 0, m_px = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      ms = 0; mbase = 0; words.delete();
      for (int i = 0; i < 10; i++) mc[i] = 0;
      m_rs = 0; m_dn = 0; m_el = 0; m_em = 0; m_pm = 0; m_px = 0;
    end else begin
      m_rs = 0; m_dn = 0;
      if (boot_valid && ms == 0) begin mc[5] = boot_link; m_el = 0; m_em = 0; end
      if (ms == 0) begin
        if (m_pm) begin m_pm = 0; if (mc[8] != 0) ms = 2; end
        else if (m_px) begin
          m_px = 0;
          if (mc[5] == 0) m_dn = 1;
          else if (mc[5][1:0] != 0) m_el = 1;
          else begin ms = 1; mbase = mc[5]; words.delete(); end
        end
      end else if (ms == 1) begin
        if (rd_err) begin m_el = 1; ms = 0; end
        else if (rd_ack) begin
          words.push_back(rd_data);
          if (words.size() == 10) begin
            for (int i = 0; i < 10; i++) if (i != 7) mc[i] = words[i];
            m_rs = 1; ms = 0;
          end
        end
      end else begin
        if (wr_err) begin m_em = 1; ms = 0; end
        else if (wr_ack) ms = 0;
      end
      if (req_served) m_pm = 1;
      if (xfer_done) m_px = 1;
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      chk("R2 rd_req", {31'd0, rd_req}, {31'd0, ms == 1});
      if (ms == 1) chk("R2 rd_addr", rd_addr, mbase + 32'(4*words.size()));
      chk("R7 wr_req", {31'd0, wr_req}, {31'd0, ms == 2});
      if (ms == 2) begin chk("R7 wr_addr", wr_addr, mc[8]); chk("R7 wr_data", wr_data, mc[9]); end
      for (int i = 0; i < 9; i++) chk("R3 cfg", cfg[i], mc[i < 7 ? i : i + 1]);
      chk("R3 restart", {31'd0, restart}, {31'd0, m_rs});
      chk("R4 chain_done", {31'd0, chain_done}, {31'd0, m_dn});
      chk("R6 err_link", {31'd0, err_link}, {31'd0, m_el});
      chk("R8 err_mask", {31'd0, err_mask}, {31'd0, m_em});
      if (restart) restarts++;
      if (chain_done) dones++;
    end
    gap = ~gap;
    rd_err = rd_req && rd_addr == BAD_RD;
    rd_ack = rd_req && gap && !rd_err;
    rd_data = (rd_req && mem.exists(rd_addr)) ? mem[rd_addr] : 32'd0;
    if (rd_ack) reads++;
    wr_err = wr_req && wr_addr == BAD_WR;
    wr_ack = wr_req && !wr_err;
    if (wr_ack) begin writes++; last_wa = wr_addr; last_wd = wr_data; end
  end

  task automatic pulse(bit b, bit x, bit s, logic [31:0] l);
    @(negedge clk);
    boot_valid = b; xfer_done = x; req_served = s; boot_link = l;
    @(negedge clk);
    boot_valid = 0; xfer_done = 0; req_served = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    put_desc(32'h100, 32'h200, 32'h8000, 32'hA5A5);
    put_desc(32'h200, 32'h0, 32'h0, 32'h1111);
    put_desc(32'h300, 32'h380, 32'h8010, 32'h2222);
    put_desc(32'h600, 32'h0, BAD_WR, 32'h3333);
    put_desc(32'h400, 32'h500, 32'h8004, 32'h4444);
    put_desc(32'h500, 32'h400, 32'h8008, 32'h5555);
    idle(4);
    rst_n = 1;
    idle(2);
    chk("R1 reset cfg_ctl", cfg[0], 0);
    chk("R1 reset flags", {28'd0, rd_req, wr_req, err_link, err_mask}, 0);

    pulse(1, 0, 0, 32'h100); pulse(0, 1, 0, 0); idle(40);
    chk("R2 reads", 32'(reads), 10);
    chk("R3 src", cfg[2], val(32'h100, 2));
    chk("R3 link", cfg[5], 32'h200);
    chk("R3 mdata not reserved", cfg[8], 32'hA5A5);
    chk("R3 restarts", 32'(restarts), 1);
    pulse(0, 0, 1, 0); idle(10);
    chk("R7 write count", 32'(writes), 1);
    chk("R7 write addr", last_wa, 32'h8000);
    chk("R7 write data", last_wd, 32'hA5A5);
    pulse(0, 1, 0, 0); idle(40);
    chk("R3 second link", cfg[5], 0);
    pulse(0, 0, 1, 0); idle(10);
    chk("R7 zero maddr skip", 32'(writes), 1);
    pulse(0, 1, 0, 0); idle(10);
    chk("R4 done", 32'(dones), 1);
    chk("R4 no read", 32'(reads), 20);

    pulse(1, 0, 0, 32'h102); pulse(0, 1, 0, 0); idle(10);
    chk("R5 err_link", {31'd0, err_link}, 1);
    chk("R5 no read", 32'(reads), 20);
    pulse(1, 0, 0, 32'h300); idle(2);
    chk("R11 err cleared", {31'd0, err_link}, 0);
    chk("R11 link", cfg[5], 32'h300);
    pulse(0, 1, 0, 0); idle(40);
    chk("R6 err_link", {31'd0, err_link}, 1);
    chk("R6 src kept", cfg[2], val(32'h200, 2));

    pulse(1, 0, 0, 32'h600); pulse(0, 1, 0, 0); idle(40);
    pulse(0, 0, 1, 0); idle(10);
    chk("R8 err_mask", {31'd0, err_mask}, 1);

    pulse(1, 0, 0, 32'h400); idle(2);
    chk("R11 mask cleared", {31'd0, err_mask}, 0);
    pulse(0, 1, 0, 0); idle(40);
    chk("R9 first", cfg[5], 32'h500);
    pulse(0, 1, 0, 0); idle(40);
    chk("R9 second", cfg[2], val(32'h500, 2));
    chk("R9 wrap link", cfg[5], 32'h400);
    pulse(0, 1, 0, 0); idle(40);
    chk("R9 wrapped", cfg[2], val(32'h400, 2));

    pulse(0, 1, 1, 0); idle(50);
    chk("R10 mask first", last_wa, 32'h8004);
    chk("R10 fetch after", cfg[5], 32'h400);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=done", cycles);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule